// File: doc/BRIEF.md
# Hot-Plug Slot Command Engine

This block executes the commands that software issues to a hot-plug slot controller. A 16-bit command word has two parts. The low byte is the operation code. The high byte names the target slot, counting from 1; a value of zero addresses the bus as a whole. The engine first decodes and validates the word. It then holds it for a fixed number of cycles. At the end of that window it either commits the effect or records an error code.

An accepted command can do one of three things:
- Change the slot-state, power-indicator and attention-indicator fields of one slot.
- Move every slot to power-only or to enabled together.
- Load a new bus speed/mode code.

While a command runs, the engine raises a busy flag and ignores further writes. When the command ends, busy drops in the same cycle that a one-cycle completion pulse is sent to the interrupt logic. A mechanical retention latch that reports open blocks any attempt to power or enable the slot behind it.

Top module: `hpc_cmd_engine`

## Requirements
- R1: The operation code is in bits 7:0 of the command word and the target slot is in bits 15:8, counting from 1. A slot operation (code 00h–3Fh) whose target is 0 or greater than NUM_SLOTS completes with error value 2 in status[3:1] and changes nothing.
- R2: A slot operation carries three subfields: bits 1:0 give the slot state (01 power-only, 10 enabled, 11 disabled), bits 3:2 give the power indicator and bits 5:4 give the attention indicator (01 on, 10 blink, 11 off). Each subfield is copied unchanged to that slot's 2-bit output field, except that 00 leaves the field as it was. No field changes at any time other than completion.
- R3: After reset every slot state reads 11 and both indicators read 11. The speed/mode output, status and the completion pulse all read 0.
- R4: A slot operation whose state subfield is 01 or 10, aimed at a slot whose mrl_open bit is 1, completes with error value 1 and leaves every field unchanged. A disable (state subfield 11) or an indicator-only operation on the same slot is still carried out.
- R5: Code 48h sets every slot state to 01 and code 49h sets every slot state to 10. If any mrl_open bit is 1, either code completes with error value 1 and changes nothing.
- R6: Codes 40h–44h load speed_mode with the code minus 40h. Codes 45h–47h complete with error value 2 and leave speed_mode unchanged.
- R7: Codes 50h–5Dh load speed_mode with the code minus 50h when iface2 is 1. When iface2 is 0 they complete with error value 4 and leave speed_mode unchanged.
- R8: Codes 4Ah–4Fh, 5Eh–BFh and C0h–FFh complete with error value 2 and change nothing.
- R9: status[0] (busy) rises on the clock edge that accepts a write made while it was 0. It stays 1 for exactly EXEC_CYCLES cycles. Any write made while it is 1 has no effect.
- R10: On the edge where busy falls, cmd_done is 1 for one cycle, and the fields and status[3:1] take their new values on that same edge. status[3:1] reads 0 while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iface2 | input | 1 | 1 when the extended speed/mode set (mode B) is supported |
| mrl_open | input | NUM_SLOTS | Per-slot retention latch open indication |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 16 | Command word: target slot in 15:8, code in 7:0 |
| status | output | 4 | Bit 0 busy, bits 3:1 error code |
| cmd_done | output | 1 | One-cycle completion pulse |
| slot_state | output | 2*NUM_SLOTS | Per-slot state field, slot n at bits 2n+1:2n |
| slot_pwr_led | output | 2*NUM_SLOTS | Per-slot power indicator field |
| slot_attn_led | output | 2*NUM_SLOTS | Per-slot attention indicator field |
| speed_mode | output | 4 | Current bus speed/mode code |

## Verification
The assertions take two things for granted. First, reset is held for at least one clock edge before it is released. Second, mrl_open and iface2 matter only on the edge that accepts a command, because they are sampled into the decoded result there. The stimulus changes every input on the falling clock edge and holds it across the next rising edge. It toggles mrl_open and iface2 only between commands, so the state a command was judged against is always defined.

// File: rtl/hpc_cmd_pkg.sv
package hpc_cmd_pkg;

    localparam logic [2:0] ERR_NONE = 3'b000;
    localparam logic [2:0] ERR_MRL  = 3'b001;
    localparam logic [2:0] ERR_BAD  = 3'b010;
    localparam logic [2:0] ERR_MODE = 3'b100;

    localparam logic [1:0] FLD_KEEP = 2'b00;
    localparam logic [1:0] ST_PWR   = 2'b01;
    localparam logic [1:0] ST_EN    = 2'b10;
    localparam logic [1:0] ST_DIS   = 2'b11;
    localparam logic [1:0] LED_OFF  = 2'b11;

    localparam logic [7:0] CODE_A_LO  = 8'h40;
    localparam logic [7:0] CODE_A_HI  = 8'h44;
    localparam logic [7:0] CODE_PWALL = 8'h48;
    localparam logic [7:0] CODE_ENALL = 8'h49;
    localparam logic [7:0] CODE_B_LO  = 8'h50;
    localparam logic [7:0] CODE_B_HI  = 8'h5D;

    typedef enum logic [1:0] {
        K_NOP   = 2'd0,
        K_SLOT  = 2'd1,
        K_ALL   = 2'd2,
        K_SPEED = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [2:0] err;
        logic [7:0] tgt;
        logic [1:0] st;
        logic [1:0] pl;
        logic [1:0] al;
        logic [3:0] spd;
    } dec_t;

endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
    import hpc_cmd_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic [15:0]          word,
    input  logic [NUM_SLOTS-1:0] mrl_open,
    input  logic                 iface2,
    output dec_t                 dec
);

    logic [7:0] code;
    logic [7:0] tgt;
    logic       tgt_ok;
    logic       sel_mrl;
    logic       wants_power;

    always_comb begin
        code        = word[7:0];
        tgt         = word[15:8];
        tgt_ok      = (tgt != 8'd0) && (int'(tgt) <= NUM_SLOTS);
        sel_mrl     = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (tgt == 8'(i + 1)) sel_mrl = mrl_open[i];
        end
        wants_power = (code[1:0] == ST_PWR) || (code[1:0] == ST_EN);

        dec.kind = K_NOP;
        dec.err  = ERR_NONE;
        dec.tgt  = tgt;
        dec.st   = code[1:0];
        dec.pl   = code[3:2];
        dec.al   = code[5:4];
        dec.spd  = code[3:0];

        if (code[7:6] == 2'b00) begin
            if (!tgt_ok)                      dec.err  = ERR_BAD;
            else if (wants_power && sel_mrl)  dec.err  = ERR_MRL;
            else                              dec.kind = K_SLOT;
        end else if (code >= CODE_A_LO && code <= CODE_A_HI) begin
            dec.kind = K_SPEED;
        end else if (code == CODE_PWALL || code == CODE_ENALL) begin
            if (|mrl_open) begin
                dec.err = ERR_MRL;
            end else begin
                dec.kind = K_ALL;
                dec.st   = code[0] ? ST_EN : ST_PWR;
            end
        end else if (code >= CODE_B_LO && code <= CODE_B_HI) begin
            if (!iface2) dec.err  = ERR_MODE;
            else         dec.kind = K_SPEED;
        end else begin
            dec.err = ERR_BAD;
        end
    end

endmodule

// File: rtl/hpc_cmd_seq.sv
module hpc_cmd_seq
    import hpc_cmd_pkg::*;
#(
    parameter int EXEC_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  dec_t       dec_in,
    output logic       busy,
    output logic       done,
    output logic [2:0] err,
    output logic       fire,
    output dec_t       held
);

    localparam int CW = (EXEC_CYCLES < 2) ? 1 : $clog2(EXEC_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(EXEC_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          done;
        logic [2:0]    err;
        dec_t          held;
    } seq_t;

    seq_t seq_d, seq_q;
    logic fire_c;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        fire_c     = seq_q.busy && (seq_q.cnt == LAST);
        if (fire_c) begin
            seq_d.busy = 1'b0;
            seq_d.done = 1'b1;
            seq_d.cnt  = '0;
            seq_d.err  = seq_q.held.err;
        end else if (seq_q.busy) begin
            seq_d.cnt  = seq_q.cnt + 1'b1;
        end else if (wr) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = '0;
            seq_d.err  = ERR_NONE;
            seq_d.held = dec_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy = seq_q.busy;
    assign done = seq_q.done;
    assign err  = seq_q.err;
    assign fire = fire_c;
    assign held = seq_q.held;

endmodule

// File: rtl/hpc_field_bank.sv
module hpc_field_bank
    import hpc_cmd_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fire,
    input  dec_t                   cmd,
    output logic [2*NUM_SLOTS-1:0] slot_state,
    output logic [2*NUM_SLOTS-1:0] slot_pwr_led,
    output logic [2*NUM_SLOTS-1:0] slot_attn_led,
    output logic [3:0]             speed_mode
);

    typedef struct packed {
        logic [1:0] st;
        logic [1:0] pl;
        logic [1:0] al;
    } fld_t;

    localparam fld_t FLD_RESET = '{st: ST_DIS, pl: LED_OFF, al: LED_OFF};

    logic commit;
    assign commit = fire && (cmd.err == ERR_NONE);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        fld_t fld_d, fld_q;
        logic hit;

        always_comb begin
            fld_d = fld_q;
            hit   = (cmd.tgt == 8'(g + 1));
            if (commit && cmd.kind == K_SLOT && hit) begin
                if (cmd.st != FLD_KEEP) fld_d.st = cmd.st;
                if (cmd.pl != FLD_KEEP) fld_d.pl = cmd.pl;
                if (cmd.al != FLD_KEEP) fld_d.al = cmd.al;
            end else if (commit && cmd.kind == K_ALL) begin
                fld_d.st = cmd.st;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) fld_q <= FLD_RESET;
            else        fld_q <= fld_d;
        end

        assign slot_state[2*g +: 2]    = fld_q.st;
        assign slot_pwr_led[2*g +: 2]  = fld_q.pl;
        assign slot_attn_led[2*g +: 2] = fld_q.al;
    end

    logic [3:0] spd_d, spd_q;

    always_comb begin
        spd_d = spd_q;
        if (commit && cmd.kind == K_SPEED) spd_d = cmd.spd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) spd_q <= '0;
        else        spd_q <= spd_d;
    end

    assign speed_mode = spd_q;

endmodule

// File: rtl/hpc_cmd_engine.sv
module hpc_cmd_engine
    import hpc_cmd_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int EXEC_CYCLES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   iface2,
    input  logic [NUM_SLOTS-1:0]   mrl_open,
    input  logic                   cmd_wr,
    input  logic [15:0]            cmd_word,
    output logic [3:0]             status,
    output logic                   cmd_done,
    output logic [2*NUM_SLOTS-1:0] slot_state,
    output logic [2*NUM_SLOTS-1:0] slot_pwr_led,
    output logic [2*NUM_SLOTS-1:0] slot_attn_led,
    output logic [3:0]             speed_mode
);

    dec_t       dec_now;
    dec_t       dec_held;
    logic       busy;
    logic       fire;
    logic [2:0] err;

    hpc_cmd_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
        .word     (cmd_word),
        .mrl_open (mrl_open),
        .iface2   (iface2),
        .dec      (dec_now)
    );

    hpc_cmd_seq #(.EXEC_CYCLES(EXEC_CYCLES)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cmd_wr),
        .dec_in (dec_now),
        .busy   (busy),
        .done   (cmd_done),
        .err    (err),
        .fire   (fire),
        .held   (dec_held)
    );

    hpc_field_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire          (fire),
        .cmd           (dec_held),
        .slot_state    (slot_state),
        .slot_pwr_led  (slot_pwr_led),
        .slot_attn_led (slot_attn_led),
        .speed_mode    (speed_mode)
    );

    assign status = {err, busy};

endmodule

// File: rtl/hpc_cmd_checker.sv
module hpc_cmd_checker #(
    parameter int NUM_SLOTS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_wr,
    input logic [3:0]             status,
    input logic                   cmd_done,
    input logic [2*NUM_SLOTS-1:0] slot_state,
    input logic [2*NUM_SLOTS-1:0] slot_pwr_led,
    input logic [2*NUM_SLOTS-1:0] slot_attn_led,
    input logic [3:0]             speed_mode
);

    AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[3:1])); // R1

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && cmd_wr) |=> status[0]); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done); // R10

    AST_DONE_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> cmd_done); // R10

    AST_ERR_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> (status[3:1] == 3'b000)); // R10

    AST_FIELDS_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({slot_state, slot_pwr_led, slot_attn_led, speed_mode}) |-> cmd_done); // R2

    AST_MRL_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && status[3:1] == 3'b001) |-> $stable(slot_state)); // R4

    AST_MODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        speed_mode <= 4'hD); // R7

endmodule

bind hpc_cmd_engine hpc_cmd_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_wr        (cmd_wr),
    .status        (status),
    .cmd_done      (cmd_done),
    .slot_state    (slot_state),
    .slot_pwr_led  (slot_pwr_led),
    .slot_attn_led (slot_attn_led),
    .speed_mode    (speed_mode)
);

// File: tb/hpc_cmd_engine_tb.sv
`timescale 1ns/1ps
module hpc_cmd_engine_tb;

    localparam int NS = 4;
    localparam int EX = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iface2 = 1'b1;
    logic [NS-1:0] mrl_open = '0;
    logic          cmd_wr = 1'b0;
    logic [15:0]   cmd_word = '0;
    logic [3:0]    status;
    logic          cmd_done;
    logic [2*NS-1:0] slot_state, slot_pwr_led, slot_attn_led;
    logic [3:0]    speed_mode;

    int nchecks = 0;
    int nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hpc_cmd_engine #(.NUM_SLOTS(NS), .EXEC_CYCLES(EX)) u_dut (
        .clk(clk), .rst_n(rst_n), .iface2(iface2), .mrl_open(mrl_open),
        .cmd_wr(cmd_wr), .cmd_word(cmd_word), .status(status), .cmd_done(cmd_done),
        .slot_state(slot_state), .slot_pwr_led(slot_pwr_led),
        .slot_attn_led(slot_attn_led), .speed_mode(speed_mode)
    );

    task automatic chk(input int act, input int exp, input string tag);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_st[NS], m_pl[NS], m_al[NS];
    int m_spd, m_err, m_cnt, m_done;
    int p_kind, p_err, p_t, p_code, p_spd, p_all;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin m_st[i] = 3; m_pl[i] = 3; m_al[i] = 3; end
            m_spd = 0; m_err = 0; m_cnt = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1;
                    m_err = p_err;
                    if (p_kind == 1) begin
                        if ((p_code & 3) != 0)        m_st[p_t] = p_code & 3;
                        if (((p_code >> 2) & 3) != 0) m_pl[p_t] = (p_code >> 2) & 3;
                        if (((p_code >> 4) & 3) != 0) m_al[p_t] = (p_code >> 4) & 3;
                    end else if (p_kind == 2) begin
                        for (int i = 0; i < NS; i++) m_st[i] = p_all;
                    end else if (p_kind == 3) begin
                        m_spd = p_spd;
                    end
                end
            end else if (cmd_wr) begin
                int code, t;
                code = int'(cmd_word[7:0]);
                t = int'(cmd_word[15:8]);
                p_err = 0; p_kind = 0;
                if (code < 64) begin
                    if (t < 1 || t > NS) p_err = 2;
                    else if (((code & 3) == 1 || (code & 3) == 2) && mrl_open[t-1]) p_err = 1;
                    else begin p_kind = 1; p_t = t - 1; p_code = code; end
                end else if (code <= 68) begin
                    p_kind = 3; p_spd = code - 64;
                end else if (code == 72 || code == 73) begin
                    if (mrl_open != 0) p_err = 1;
                    else begin p_kind = 2; p_all = (code == 73) ? 2 : 1; end
                end else if (code >= 80 && code <= 93) begin
                    if (!iface2) p_err = 4;
                    else begin p_kind = 3; p_spd = code - 80; end
                end else p_err = 2;
                m_cnt = EX;
                m_err = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int i = 0; i < NS; i++) begin
                chk(int'(slot_state[2*i +: 2]), m_st[i], "R2 state vs model");
                chk(int'(slot_pwr_led[2*i +: 2]), m_pl[i], "R2 power led vs model");
                chk(int'(slot_attn_led[2*i +: 2]), m_al[i], "R2 attn led vs model");
            end
            chk(int'(speed_mode), m_spd, "R6 speed vs model");
            chk(int'(status[0]), (m_cnt > 0) ? 1 : 0, "R9 busy vs model");
            chk(int'(status[3:1]), m_err, "R10 error vs model");
            chk(int'(cmd_done), m_done, "R10 done vs model");
        end
    end

    task automatic run_cmd(input logic [7:0] tgt, input logic [7:0] code);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_word = {tgt, code};
        @(negedge clk);
        cmd_wr = 1'b0;
        for (int k = 0; k < 40 && !cmd_done; k++) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            nerr++; nchecks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R3 reset values
        chk(int'(status), 0, "R3 status at reset");
        chk(int'(slot_state), 8'hFF, "R3 state at reset");
        chk(int'(slot_attn_led), 8'hFF, "R3 attn at reset");
        chk(int'(speed_mode), 0, "R3 speed at reset");
        chk(int'(cmd_done), 0, "R3 done at reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 enable + blink + attn off on slot 1
        run_cmd(8'd1, 8'h3A);
        chk(int'(slot_state[1:0]), 2, "R2 slot1 state");
        chk(int'(slot_pwr_led[1:0]), 2, "R2 slot1 power led");
        chk(int'(status[3:1]), 0, "R2 no error");
        run_cmd(8'd1, 8'h10);
        chk(int'(slot_attn_led[1:0]), 1, "R2 attn on");
        chk(int'(slot_state[1:0]), 2, "R2 state kept by 00 subfield");

        // R1 bad targets
        run_cmd(8'd0, 8'h01);
        chk(int'(status[3:1]), 2, "R1 target zero");
        run_cmd(8'd5, 8'h01);
        chk(int'(status[3:1]), 2, "R1 target above count");
        chk(int'(slot_state), 8'hFE, "R1 nothing changed");

        // R4 retention latch open
        mrl_open = 4'b0100;
        run_cmd(8'd3, 8'h01);
        chk(int'(status[3:1]), 1, "R4 power rejected");
        chk(int'(slot_state[5:4]), 3, "R4 state unchanged");
        run_cmd(8'd3, 8'h13);
        chk(int'(status[3:1]), 0, "R4 disable allowed");
        chk(int'(slot_attn_led[5:4]), 1, "R4 disable applied");

        // R5 all-slot commands
        run_cmd(8'd0, 8'h49);
        chk(int'(status[3:1]), 1, "R5 all blocked by latch");
        chk(int'(slot_state), 8'hFE, "R5 unchanged");
        mrl_open = '0;
        run_cmd(8'd0, 8'h49);
        chk(int'(slot_state), 8'hAA, "R5 enable all");
        run_cmd(8'd0, 8'h48);
        chk(int'(slot_state), 8'h55, "R5 power all");

        // R6 mode A
        run_cmd(8'd0, 8'h43);
        chk(int'(speed_mode), 3, "R6 mode A load");
        run_cmd(8'd0, 8'h46);
        chk(int'(status[3:1]), 2, "R6 reserved A code");
        chk(int'(speed_mode), 3, "R6 speed kept");

        // R7 mode B
        run_cmd(8'd0, 8'h5C);
        chk(int'(speed_mode), 12, "R7 mode B load");
        iface2 = 1'b0;
        run_cmd(8'd0, 8'h52);
        chk(int'(status[3:1]), 4, "R7 mode B under rev1");
        chk(int'(speed_mode), 12, "R7 speed kept");
        iface2 = 1'b1;

        // R8 reserved and vendor codes
        run_cmd(8'd1, 8'h60);
        chk(int'(status[3:1]), 2, "R8 code 60h");
        run_cmd(8'd1, 8'hC5);
        chk(int'(status[3:1]), 2, "R8 vendor code");
        run_cmd(8'd0, 8'h4B);
        chk(int'(status[3:1]), 2, "R8 code 4Bh");
        chk(int'(slot_state), 8'h55, "R8 nothing changed");

        // R9 / R10 busy window, ignored write, single pulse
        begin
            int bcount, dcount;
            bcount = 0; dcount = 0;
            @(negedge clk);
            cmd_wr = 1'b1;
            cmd_word = {8'd2, 8'h02};
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (k == 0) begin
                    chk(int'(status[0]), 1, "R9 busy after accept");
                    cmd_word = {8'd2, 8'h10};
                end
                if (k == 1) cmd_wr = 1'b0;
                if (status[0]) bcount++;
                if (status[0]) chk(int'(status[3:1]), 0, "R10 error quiet while busy");
                if (cmd_done) dcount++;
            end
            chk(bcount, EX, "R9 busy length");
            chk(dcount, 1, "R10 single done pulse");
            chk(int'(slot_state[3:2]), 2, "R9 first command applied");
            chk(int'(slot_attn_led[3:2]), 3, "R9 write while busy ignored");
        end

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

endmodule